// File: doc/BRIEF.md
# I/O Register Window with Processor Status Register

This block is the I/O register window of a small 8-bit processor core. The same register set can be reached in two ways. I/O-instruction accesses use a six-bit I/O address. Data-memory loads and stores use an eight-bit data address that is the I/O address plus 0x20. The lower 32 I/O addresses also accept single-bit set, clear and test operations. The set and clear operations read the whole register, modify it and write it back. Test operations return a one-cycle skip indication.

The window holds the processor status register. This register takes masked flag updates from the ALU, interrupt entry and return events, and bit-copy store operations. The block also returns the result of a bit-copy load. A small group of generic peripheral registers stands in for the peripherals:
- a bank of write-one-to-clear event flags, set by hardware;
- a matching bank of per-line enables;
- two plain data registers.

A flagged and enabled event is passed on as an interrupt request only while the global interrupt enable bit is set. Reads are combinational on the address. Every state change happens at the rising clock edge. A synchronous active-high reset clears all state.

Top module: `iowin`

## Requirements
- R1: After reset every register reads 0: the status register, the flags, the enables and both data registers. `irq_out` is 0.
- R2: The register map is as follows, by I/O address:
  - flags at 0x0A (bits 3:0);
  - enables at 0x0B (bits 3:0);
  - data 0 at 0x12;
  - data 1 at 0x2C;
  - status register at 0x3F.

  A data-memory access at address A reaches I/O address A-0x20 only for A in 0x20..0x5F. Outside that window a data read returns 0 and a data write has no effect on any register.
- R3: An address with no register reads 0, and writes to it are ignored. Bits 7:4 of the flag and enable registers read 0.
- R4: A bit operation is encoded by `bop_kind`:
  - 0: set;
  - 1: clear;
  - 2: skip-if-set;
  - 3: skip-if-clear.

  Set and clear at an address in 0x00..0x1F write back the whole register with bit `bop_sel` forced to 1 or 0. The change takes effect at the next clock edge.
- R5: Writing the flag register clears every flag written with 1. A bit set or clear on the flag register writes back the value it read, so every flag read as 1 is cleared, except the target of a clear. A hardware flag set in the same cycle wins.
- R6: In the cycle after a legal test operation, `bop_skip` equals the selected bit for skip-if-set and its inverse for skip-if-clear. After any other operation, or when there is no operation, it is 0.
- R7: A bit operation with an address above 0x1F raises `bop_illegal` for one cycle after it and changes no register.
- R8: The status register bit order, from bit 7 to bit 0, is I, T, H, S, V, N, Z, C. S always reads as N XOR V, and a write to S is ignored.
- R9: `alu_we` and `alu_flags` hold H, V, N, Z, C in bits 4..0. Only the flags whose enable bit is set are updated. A direct write to the status register in the same cycle overrides the whole update.
- R10: `irq_take` clears I and `irq_return` sets I. If both arrive together, take wins. A direct write overrides both.
- R11: `irq_out[k]` is flag k AND enable k while I is 1, and is all zeros while I is 0.
- R12: A bit-copy store with `bst_valid` copies `bst_opnd[bst_sel]` into T at the next edge. `bld_result` is `bld_opnd` with bit `bld_sel` replaced by the current T.
- R13: When writers collide in one cycle, a set or clear bit operation has priority over an I/O write, and an I/O write has priority over a data-memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O-view address |
| io_wr | input | 1 | I/O-view write strobe |
| io_wdata | input | 8 | I/O-view write data |
| io_rdata | output | 8 | I/O-view read data (combinational) |
| dm_addr | input | 8 | Data-memory-view address |
| dm_wr | input | 1 | Data-memory-view write strobe |
| dm_wdata | input | 8 | Data-memory-view write data |
| dm_rdata | output | 8 | Data-memory-view read data (combinational) |
| bop_valid | input | 1 | Bit operation request |
| bop_kind | input | 2 | Bit operation kind |
| bop_addr | input | 6 | Bit operation I/O address |
| bop_sel | input | 3 | Bit operation bit index |
| bop_skip | output | 1 | Skip result, one cycle after a test |
| bop_illegal | output | 1 | Out-of-range bit operation, one cycle after it |
| alu_we | input | 5 | Per-flag update enable {H,V,N,Z,C} |
| alu_flags | input | 5 | New flag values {H,V,N,Z,C} |
| irq_take | input | 1 | Interrupt entry event |
| irq_return | input | 1 | Return-from-interrupt event |
| bst_valid | input | 1 | Bit-copy store request |
| bst_opnd | input | 8 | Bit-copy store operand |
| bst_sel | input | 3 | Bit-copy store bit index |
| bld_opnd | input | 8 | Bit-copy load operand |
| bld_sel | input | 3 | Bit-copy load bit index |
| bld_result | output | 8 | Bit-copy load result |
| hw_flag_set | input | 4 | Hardware event flag set pulses |
| irq_out | output | 4 | Gated interrupt requests |

## Verification
The bench targets the side effects of read-modify-write on write-one-to-clear flags. A design that wrote back only the target bit would leave the other set flags standing after a bit set or clear. It also uses a data address of 0x72, whose offset wraps onto data register 0 when truncated to six bits. A design that skipped the window check would corrupt that register. Status register checks cover these cases:
- all ones written, where S must read 0 because N XOR V is 0;
- masked ALU updates colliding with a direct write, where a design with the wrong priority shows ALU flags;
- simultaneous interrupt take and return.

Collisions between writers and out-of-range bit operations are checked through the registers they must or must not change.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int unsigned IO_AW = 6;
    localparam int unsigned DM_AW = 8;
    localparam int unsigned DW    = 8;

    localparam logic [DM_AW-1:0] DM_BASE = 8'h20;
    localparam logic [DM_AW-1:0] DM_LAST = 8'h5F;

    localparam logic [IO_AW-1:0] A_FLG     = 6'h0A;
    localparam logic [IO_AW-1:0] A_ENA     = 6'h0B;
    localparam logic [IO_AW-1:0] A_DAT0    = 6'h12;
    localparam logic [IO_AW-1:0] A_DAT1    = 6'h2C;
    localparam logic [IO_AW-1:0] A_SREG    = 6'h3F;
    localparam logic [IO_AW-1:0] BIT_LIMIT = 6'h1F;

    typedef enum logic [1:0] {
        BOP_SET = 2'd0,
        BOP_CLR = 2'd1,
        BOP_SKS = 2'd2,
        BOP_SKC = 2'd3
    } bop_kind_e;

    // Stored status bits; the sign bit is derived on read.
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_st_t;

    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic             en;
        logic [IO_AW-1:0] addr;
        logic [DW-1:0]    data;
    } wr_req_t;

    function automatic logic [DW-1:0] sreg_pack(input sreg_st_t s);
        return {s.i, s.t, s.h, s.n ^ s.v, s.v, s.n, s.z, s.c};
    endfunction

    function automatic sreg_st_t sreg_unpack(input logic [DW-1:0] d);
        sreg_st_t s;
        s.i = d[7];
        s.t = d[6];
        s.h = d[5];
        s.v = d[3];
        s.n = d[2];
        s.z = d[1];
        s.c = d[0];
        return s;
    endfunction

    function automatic logic is_test(input bop_kind_e k);
        return (k == BOP_SKS) || (k == BOP_SKC);
    endfunction

    function automatic logic dm_in_window(input logic [DM_AW-1:0] a);
        return (a >= DM_BASE) && (a <= DM_LAST);
    endfunction

endpackage

// File: rtl/iow_sreg.sv
module iow_sreg
    import iow_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dwr_en,
    input  logic [DW-1:0] dwr_data,
    input  alu_flags_t    alu_we,
    input  alu_flags_t    alu_val,
    input  logic          irq_take,
    input  logic          irq_return,
    input  logic          bst_valid,
    input  logic          bst_bit,
    output sreg_st_t      q
);

    sreg_st_t nxt;

    always_comb begin
        nxt = q;
        if (alu_we.h) nxt.h = alu_val.h;
        if (alu_we.v) nxt.v = alu_val.v;
        if (alu_we.n) nxt.n = alu_val.n;
        if (alu_we.z) nxt.z = alu_val.z;
        if (alu_we.c) nxt.c = alu_val.c;
        if (bst_valid) nxt.t = bst_bit;
        if (irq_take)        nxt.i = 1'b0;
        else if (irq_return) nxt.i = 1'b1;
        if (dwr_en) nxt = sreg_unpack(dwr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/iow_periph.sv
module iow_periph
    import iow_pkg::*;
#(
    parameter int unsigned NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    input  logic [NFLAG-1:0] hw_set,
    output logic [NFLAG-1:0] flg,
    output logic [NFLAG-1:0] ena,
    output logic [DW-1:0]    dat0,
    output logic [DW-1:0]    dat1
);

    logic hit_flg, hit_ena, hit_d0, hit_d1;

    assign hit_flg = wr.en && (wr.addr == A_FLG);
    assign hit_ena = wr.en && (wr.addr == A_ENA);
    assign hit_d0  = wr.en && (wr.addr == A_DAT0);
    assign hit_d1  = wr.en && (wr.addr == A_DAT1);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg  <= '0;
            ena  <= '0;
            dat0 <= '0;
            dat1 <= '0;
        end else begin
            flg <= (hit_flg ? (flg & ~wr.data[NFLAG-1:0]) : flg) | hw_set;
            if (hit_ena) ena  <= wr.data[NFLAG-1:0];
            if (hit_d0)  dat0 <= wr.data;
            if (hit_d1)  dat1 <= wr.data;
        end
    end

endmodule

// File: rtl/iow_bitop.sv
module iow_bitop
    import iow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  bop_kind_e        kind,
    input  logic [IO_AW-1:0] addr,
    input  logic [2:0]       sel,
    input  logic [DW-1:0]    cur,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic             skip,
    output logic             illegal
);

    logic          legal;
    logic [DW-1:0] mask;
    logic          tbit;
    logic          skip_nxt;

    assign legal   = addr <= BIT_LIMIT;
    assign mask    = DW'(1) << sel;
    assign tbit    = cur[sel];
    assign wr_en   = valid && legal && !is_test(kind);
    assign wr_data = (kind == BOP_SET) ? (cur | mask) : (cur & ~mask);

    always_comb begin
        skip_nxt = 1'b0;
        if (valid && legal) begin
            if (kind == BOP_SKS)      skip_nxt = tbit;
            else if (kind == BOP_SKC) skip_nxt = !tbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            skip    <= skip_nxt;
            illegal <= valid && !legal;
        end
    end

endmodule

// File: rtl/iowin.sv
module iowin
    import iow_pkg::*;
#(
    parameter int unsigned NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [7:0]       dm_addr,
    input  logic             dm_wr,
    input  logic [7:0]       dm_wdata,
    output logic [7:0]       dm_rdata,
    input  logic             bop_valid,
    input  logic [1:0]       bop_kind,
    input  logic [5:0]       bop_addr,
    input  logic [2:0]       bop_sel,
    output logic             bop_skip,
    output logic             bop_illegal,
    input  logic [4:0]       alu_we,
    input  logic [4:0]       alu_flags,
    input  logic             irq_take,
    input  logic             irq_return,
    input  logic             bst_valid,
    input  logic [7:0]       bst_opnd,
    input  logic [2:0]       bst_sel,
    input  logic [7:0]       bld_opnd,
    input  logic [2:0]       bld_sel,
    output logic [7:0]       bld_result,
    input  logic [NFLAG-1:0] hw_flag_set,
    output logic [NFLAG-1:0] irq_out
);

    sreg_st_t         sreg_q;
    logic [DW-1:0]    sreg_val;
    logic             sreg_wr;
    logic [NFLAG-1:0] flg, ena;
    logic [DW-1:0]    dat0, dat1;
    logic [DW-1:0]    bop_rd;
    logic             bop_wen;
    logic [DW-1:0]    bop_wdata;
    logic             dm_hit;
    logic [IO_AW-1:0] dm_idx;
    wr_req_t          wr;

    assign sreg_val = sreg_pack(sreg_q);

    function automatic logic [DW-1:0] rd_reg(input logic [IO_AW-1:0] a);
        case (a)
            A_FLG:   return DW'(flg);
            A_ENA:   return DW'(ena);
            A_DAT0:  return dat0;
            A_DAT1:  return dat1;
            A_SREG:  return sreg_val;
            default: return '0;
        endcase
    endfunction

    assign dm_hit   = dm_in_window(dm_addr);
    assign dm_idx   = IO_AW'(dm_addr - DM_BASE);
    assign io_rdata = rd_reg(io_addr);
    assign dm_rdata = dm_hit ? rd_reg(dm_idx) : '0;
    assign bop_rd   = rd_reg(bop_addr);

    iow_bitop u_bitop (
        .clk     (clk),
        .rst     (rst),
        .valid   (bop_valid),
        .kind    (bop_kind_e'(bop_kind)),
        .addr    (bop_addr),
        .sel     (bop_sel),
        .cur     (bop_rd),
        .wr_en   (bop_wen),
        .wr_data (bop_wdata),
        .skip    (bop_skip),
        .illegal (bop_illegal)
    );

    // Single write port: bit op, then I/O view, then data view.
    always_comb begin
        wr = '0;
        if (bop_wen) begin
            wr.en = 1'b1; wr.addr = bop_addr; wr.data = bop_wdata;
        end else if (io_wr) begin
            wr.en = 1'b1; wr.addr = io_addr; wr.data = io_wdata;
        end else if (dm_wr && dm_hit) begin
            wr.en = 1'b1; wr.addr = dm_idx; wr.data = dm_wdata;
        end
    end

    assign sreg_wr = wr.en && (wr.addr == A_SREG);

    iow_periph #(.NFLAG(NFLAG)) u_periph (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .hw_set (hw_flag_set),
        .flg    (flg),
        .ena    (ena),
        .dat0   (dat0),
        .dat1   (dat1)
    );

    iow_sreg u_sreg (
        .clk        (clk),
        .rst        (rst),
        .dwr_en     (sreg_wr),
        .dwr_data   (wr.data),
        .alu_we     (alu_flags_t'(alu_we)),
        .alu_val    (alu_flags_t'(alu_flags)),
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .bst_valid  (bst_valid),
        .bst_bit    (bst_opnd[bst_sel]),
        .q          (sreg_q)
    );

    always_comb begin
        bld_result          = bld_opnd;
        bld_result[bld_sel] = sreg_q.t;
    end

    for (genvar k = 0; k < NFLAG; k++) begin : g_irq
        assign irq_out[k] = sreg_q.i && flg[k] && ena[k];
    end

endmodule

// File: rtl/iow_checker.sv
module iow_checker #(
    parameter int unsigned NFLAG = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bop_valid,
    input logic [1:0]       bop_kind,
    input logic [5:0]       bop_addr,
    input logic             bop_skip,
    input logic             bop_illegal,
    input logic             irq_take,
    input logic             irq_return,
    input logic             bst_valid,
    input logic [7:0]       bst_opnd,
    input logic [2:0]       bst_sel,
    input logic [NFLAG-1:0] irq_out,
    input logic [7:0]       sreg_val,
    input logic             sreg_wr
);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (sreg_val == 8'h00 && irq_out == '0)
                else $error("status or irq not cleared by reset");
        end
    end

    assert_illegal_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        bop_valid && (bop_addr > 6'h1F) |=> bop_illegal);

    assert_skip_source_R6: assert property (@(posedge clk) disable iff (rst)
        bop_skip |-> $past(bop_valid && bop_kind[1] && (bop_addr <= 6'h1F)));

    assert_take_clears_R10: assert property (@(posedge clk) disable iff (rst)
        irq_take && !sreg_wr |=> !sreg_val[7]);

    assert_return_sets_R10: assert property (@(posedge clk) disable iff (rst)
        irq_return && !irq_take && !sreg_wr |=> sreg_val[7]);

    assert_bit_store_R12: assert property (@(posedge clk) disable iff (rst)
        bst_valid && !sreg_wr |=> sreg_val[6] == $past(bst_opnd[bst_sel]));

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !sreg_val[7] |-> irq_out == '0);

endmodule

bind iowin iow_checker #(.NFLAG(NFLAG)) u_chk (.*);

// File: tb/iowin_bench.sv
module iowin_bench;

    localparam int NFLAG = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [5:0]       io_addr = '0;
    logic             io_wr = 1'b0;
    logic [7:0]       io_wdata = '0;
    logic [7:0]       io_rdata;
    logic [7:0]       dm_addr = '0;
    logic             dm_wr = 1'b0;
    logic [7:0]       dm_wdata = '0;
    logic [7:0]       dm_rdata;
    logic             bop_valid = 1'b0;
    logic [1:0]       bop_kind = '0;
    logic [5:0]       bop_addr = '0;
    logic [2:0]       bop_sel = '0;
    logic             bop_skip, bop_illegal;
    logic [4:0]       alu_we = '0;
    logic [4:0]       alu_flags = '0;
    logic             irq_take = 1'b0;
    logic             irq_return = 1'b0;
    logic             bst_valid = 1'b0;
    logic [7:0]       bst_opnd = '0;
    logic [2:0]       bst_sel = '0;
    logic [7:0]       bld_opnd = '0;
    logic [2:0]       bld_sel = '0;
    logic [7:0]       bld_result;
    logic [NFLAG-1:0] hw_flag_set = '0;
    logic [NFLAG-1:0] irq_out;

    iowin #(.NFLAG(NFLAG)) u_iowin (.*);

    always #2 clk = ~clk;

    typedef struct {
        string      tag;
        int         src;
        logic [7:0] exp;
    } item_t;

    item_t exp_q[$];
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;

    // Monitor: sample between edges and compare against queued items.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = exp_q.pop_front();
            case (it.src)
                0: act = io_rdata;
                1: act = dm_rdata;
                2: act = {7'd0, bop_skip};
                3: act = {7'd0, bop_illegal};
                4: act = 8'(irq_out);
                default: act = bld_result;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int src, input logic [7:0] exp, input string tag);
        item_t it;
        it.tag = tag; it.src = src; it.exp = exp;
        exp_q.push_back(it);
        tick();
    endtask

    task automatic chk_io(input logic [5:0] a, input logic [7:0] e, input string tag);
        io_addr = a;
        push(0, e, tag);
    endtask

    task automatic chk_dm(input logic [7:0] a, input logic [7:0] e, input string tag);
        dm_addr = a;
        push(1, e, tag);
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic dm_write(input logic [7:0] a, input logic [7:0] d);
        dm_wr = 1'b1; dm_addr = a; dm_wdata = d;
        tick();
        dm_wr = 1'b0;
    endtask

    task automatic bit_op(input logic [1:0] k, input logic [5:0] a, input logic [2:0] s);
        bop_valid = 1'b1; bop_kind = k; bop_addr = a; bop_sel = s;
        tick();
        bop_valid = 1'b0;
    endtask

    task automatic hw_set(input logic [NFLAG-1:0] v);
        hw_flag_set = v;
        tick();
        hw_flag_set = '0;
    endtask

    task automatic alu(input logic [4:0] we, input logic [4:0] f);
        alu_we = we; alu_flags = f;
        tick();
        alu_we = '0;
    endtask

    task automatic bstore(input logic [7:0] o, input logic [2:0] s);
        bst_valid = 1'b1; bst_opnd = o; bst_sel = s;
        tick();
        bst_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_io(6'h3F, 8'h00, "R1 status after reset");
        chk_io(6'h0A, 8'h00, "R1 flags after reset");
        chk_io(6'h12, 8'h00, "R1 data0 after reset");
        push(4, 8'h00, "R1 irq_out after reset");

        // R2 dual views
        io_write(6'h12, 8'hA5);
        chk_io(6'h12, 8'hA5, "R2 io read data0");
        chk_dm(8'h32, 8'hA5, "R2 dm read data0");
        dm_write(8'h4C, 8'h3C);
        chk_io(6'h2C, 8'h3C, "R2 dm write data1");
        dm_write(8'h72, 8'h11);
        chk_io(6'h12, 8'hA5, "R2 out-of-window dm write ignored");
        chk_dm(8'h10, 8'h00, "R2 out-of-window dm read zero");

        // R3 reserved
        io_write(6'h05, 8'hFF);
        chk_io(6'h05, 8'h00, "R3 reserved addr");
        io_write(6'h0B, 8'hFF);
        chk_io(6'h0B, 8'h0F, "R3 enable reserved bits");

        // R4 set/clear
        bit_op(2'd0, 6'h12, 3'd1);
        chk_io(6'h12, 8'hA7, "R4 bit set");
        bit_op(2'd1, 6'h12, 3'd0);
        chk_io(6'h12, 8'hA6, "R4 bit clear");

        // R6 skip tests (data0 = A6)
        bit_op(2'd2, 6'h12, 3'd2);
        push(2, 8'h01, "R6 skip-if-set on 1");
        bit_op(2'd3, 6'h12, 3'd2);
        push(2, 8'h00, "R6 skip-if-clear on 1");
        bit_op(2'd3, 6'h12, 3'd0);
        push(2, 8'h01, "R6 skip-if-clear on 0");
        bit_op(2'd0, 6'h12, 3'd1);
        push(2, 8'h00, "R6 no skip after set");
        bit_op(2'd2, 6'h05, 3'd0);
        push(2, 8'h00, "R6 skip-if-set on reserved addr");

        // R7 illegal
        bit_op(2'd0, 6'h2C, 3'd0);
        push(3, 8'h01, "R7 illegal pulse");
        chk_io(6'h2C, 8'h3C, "R7 no change on illegal");
        bit_op(2'd0, 6'h12, 3'd1);
        push(3, 8'h00, "R7 legal op no pulse");

        // R5 write-one-to-clear
        hw_set(4'hF);
        chk_io(6'h0A, 8'h0F, "R5 hw set flags");
        io_write(6'h0A, 8'h05);
        chk_io(6'h0A, 8'h0A, "R5 w1c write");
        hw_set(4'hF);
        bit_op(2'd1, 6'h0A, 3'd1);
        chk_io(6'h0A, 8'h02, "R5 clear side effect");
        hw_set(4'hF);
        bit_op(2'd0, 6'h0A, 3'd0);
        chk_io(6'h0A, 8'h00, "R5 set side effect");
        hw_flag_set = 4'h1;
        io_write(6'h0A, 8'h01);
        hw_flag_set = '0;
        chk_io(6'h0A, 8'h01, "R5 hw set wins");

        // R8/R9 status register
        io_write(6'h3F, 8'hFF);
        chk_io(6'h3F, 8'hEF, "R8 sign derived");
        io_write(6'h3F, 8'h00);
        alu(5'b11111, 5'b01001);
        chk_io(6'h3F, 8'h19, "R9 full flag update");
        alu(5'b00100, 5'b00100);
        chk_io(6'h3F, 8'h0D, "R9 masked flag update");
        alu_we = 5'b11111; alu_flags = 5'b11111;
        io_write(6'h3F, 8'h01);
        alu_we = '0;
        chk_io(6'h3F, 8'h01, "R9 direct write priority");

        // R10 interrupt enable events
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        chk_io(6'h3F, 8'h81, "R10 return sets I");
        irq_take = 1'b1; tick(); irq_take = 1'b0;
        chk_io(6'h3F, 8'h01, "R10 take clears I");
        irq_return = 1'b1; tick();
        irq_take = 1'b1; tick();
        irq_take = 1'b0; irq_return = 1'b0;
        chk_io(6'h3F, 8'h01, "R10 take wins over return");

        // R11 interrupt gating
        io_write(6'h0A, 8'hFF);
        hw_set(4'h3);
        push(4, 8'h00, "R11 masked by I=0");
        irq_return = 1'b1; tick(); irq_return = 1'b0;
        push(4, 8'h03, "R11 passed with I=1");
        io_write(6'h0B, 8'h01);
        push(4, 8'h01, "R11 per-line enable");

        // R12 bit copy
        bstore(8'h40, 3'd6);
        chk_io(6'h3F, 8'hC1, "R12 store sets T");
        bld_opnd = 8'h00; bld_sel = 3'd3;
        push(5, 8'h08, "R12 load inserts T=1");
        bstore(8'h40, 3'd5);
        chk_io(6'h3F, 8'h81, "R12 store clears T");
        bld_opnd = 8'hFF; bld_sel = 3'd0;
        push(5, 8'hFE, "R12 load inserts T=0");

        // R13 write priority
        io_wr = 1'b1; io_addr = 6'h12; io_wdata = 8'h11;
        dm_wr = 1'b1; dm_addr = 8'h32; dm_wdata = 8'h22;
        tick();
        io_wr = 1'b0; dm_wr = 1'b0;
        chk_io(6'h12, 8'h11, "R13 io over dm");
        io_wr = 1'b1; io_addr = 6'h12; io_wdata = 8'h00;
        bit_op(2'd0, 6'h12, 3'd7);
        io_wr = 1'b0;
        chk_io(6'h12, 8'h91, "R13 bit op over io");

        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule